// File: doc/BRIEF.md
# Prioritized Active Interrupt Resolver

This block turns a snapshot of pending interrupt state into the single interrupt number that a handler should service next. It watches a 21-bit summary word and two 32-bit bank words, and on every clock it registers one flat interrupt number in the range 0 to 71 along with a flag that says whether any number was found. Local sources own numbers 0 to 7, bank A lines map to 8 to 39 and bank B lines map to 40 to 71.

The search is not one flat lowest-bit encoder. It runs in stages. Local sources are tried first. Next come the summary shortcut bits, which mirror a few selected bank lines. After those, each bank word is searched only if its summary flag is set, and only after its shortcut lines have been masked out. The summary word layout is fixed, because the block decodes it:

- bits 7:0 are local sources.
- bit 8 is the bank A flag and bit 9 is the bank B flag.
- bits 14:10 are the bank A shortcuts for lines 7, 9, 10, 18 and 19, in that bit order.
- bits 20:15 are the bank B shortcuts for lines 21, 22, 23, 24, 25 and 30, in that bit order.

Top module: `irqResolver`

## Requirements
- R1: When the summary word is zero, one clock later the valid output is low and the number output is 0, whatever the bank words hold.
- R2: When any of summary bits 7:0 is set, one clock later the valid output is high and the number is the index of the lowest set bit among them.
- R3: When bits 7:0 are clear and any of summary bits 14:10 is set, the lowest set bit among bits 14:10 is taken. Bits 10, 11, 12, 13 and 14 select bank A lines 7, 9, 10, 18 and 19, and the number is 8 plus that line.
- R4: When bits 14:0 give no result under R2 and R3, and any of summary bits 20:15 is set, the lowest set bit among bits 20:15 is taken. Bits 15 to 20 select bank B lines 21, 22, 23, 24, 25 and 30, and the number is 40 plus that line.
- R5: When no earlier stage hits and summary bit 8 is set, the bank A word is searched with lines 7, 9, 10, 18 and 19 forced to zero. The number is 8 plus the index of the lowest remaining set bit.
- R6: When no earlier stage hits and summary bit 9 is set, the bank B word is searched with lines 21, 22, 23, 24, 25 and 30 forced to zero. The number is 40 plus the index of the lowest remaining set bit.
- R7: A bank word whose summary flag is clear is ignored. A flagged bank whose masked word is zero lets the search go on to the next stage. If no stage hits, valid is low.
- R8: The stages rank local, then bank A shortcuts, then bank B shortcuts, then bank A word, then bank B word. A hit in an earlier stage wins over any later one.
- R9: The output changes only on the clock edge after the inputs change. An active-low reset clears valid and the number at once, without waiting for a clock edge.
- R10: Whenever valid is low, the number output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sumWord | input | 21 | Summary pending word (layout above) |
| bankAWord | input | 32 | Bank A pending lines |
| bankBWord | input | 32 | Bank B pending lines |
| irqNum | output | 7 | Registered flat interrupt number, 0 when not valid |
| irqValid | output | 1 | Registered flag, high when a number was found |

## Verification
The hardest case to reach is a bank flag that is set while its bank word holds only shortcut lines and the matching summary shortcut bits are clear. Consistent sources never produce this state. Driving the ports directly makes it possible, so the stimulus sets exactly that combination. It then checks that the search falls through, either to bank B or to no result. Further vectors set bits in several stages at once, to confirm the ranking, and put set bits on bank lines that the summary flag leaves unflagged, to confirm those lines are ignored.

// File: rtl/irqResolver_pkg.sv
package irqResolver_pkg;

  localparam int SUM_W      = 21;
  localparam int BANK_W     = 32;
  localparam int NUM_W      = 7;
  localparam int LINE_W     = 5;
  localparam int LOC_N      = 8;
  localparam int FLAG_A_POS = 8;
  localparam int FLAG_B_POS = 9;
  localparam int SHA_LO     = 10;
  localparam int SHA_N      = 5;
  localparam int SHB_LO     = SHA_LO + SHA_N;
  localparam int SHB_N      = 6;
  localparam int TBL_W      = SHB_N * LINE_W;
  localparam int BANKA_BASE = LOC_N;
  localparam int BANKB_BASE = BANKA_BASE + BANK_W;

  // Bank line mirrored by each shortcut bit, lowest shortcut bit in the lowest slot.
  localparam logic [SHA_N*LINE_W-1:0] SHA_LINES = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7};
  localparam logic [SHB_N*LINE_W-1:0] SHB_LINES = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21};

  function automatic logic [LINE_W-1:0] lineAt(input logic [TBL_W-1:0] tbl, input int n,
                                               input int idx);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = 0; i < SHB_N; i++)
      if (i < n && i == idx) r = tbl[i*LINE_W +: LINE_W];
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] maskOf(input logic [TBL_W-1:0] tbl, input int n);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < SHB_N; i++)
      if (i < n) m[tbl[i*LINE_W +: LINE_W]] = 1'b1;
    return m;
  endfunction

  localparam logic [BANK_W-1:0] MASK_A = maskOf(TBL_W'(SHA_LINES), SHA_N);
  localparam logic [BANK_W-1:0] MASK_B = maskOf(TBL_W'(SHB_LINES), SHB_N);

  typedef struct packed {
    logic locHit;
    logic shAHit;
    logic shBHit;
    logic bkAHit;
    logic bkBHit;
  } hitFlags_t;

  typedef struct packed {
    logic selLoc;
    logic selShA;
    logic selShB;
    logic selBkA;
    logic selBkB;
  } stageSel_t;

endpackage

// File: rtl/irqLsbEncoder.sv
module irqLsbEncoder #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/irqResolverCtrl.sv
module irqResolverCtrl
  import irqResolver_pkg::*;
(
  input  hitFlags_t hits,
  output stageSel_t sel
);
  always_comb begin
    sel = '0;
    if (hits.locHit)      sel.selLoc = 1'b1;
    else if (hits.shAHit) sel.selShA = 1'b1;
    else if (hits.shBHit) sel.selShB = 1'b1;
    else if (hits.bkAHit) sel.selBkA = 1'b1;
    else if (hits.bkBHit) sel.selBkB = 1'b1;
  end
endmodule

// File: rtl/irqResolverDp.sv
module irqResolverDp
  import irqResolver_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUM_W-1:0] sumWord,
  input  logic [BANK_W-1:0] bankAWord,
  input  logic [BANK_W-1:0] bankBWord,
  input  stageSel_t        sel,
  output hitFlags_t        hits,
  output logic [NUM_W-1:0] irqNum,
  output logic             irqValid
);
  localparam int LOC_IW  = $clog2(LOC_N);
  localparam int SHA_IW  = $clog2(SHA_N);
  localparam int SHB_IW  = $clog2(SHB_N);
  localparam int BANK_IW = $clog2(BANK_W);

  logic [LOC_IW-1:0]  locIdx;
  logic [SHA_IW-1:0]  shAIdx;
  logic [SHB_IW-1:0]  shBIdx;
  logic [BANK_IW-1:0] bkAIdx, bkBIdx;
  logic               locAny, shAAny, shBAny, bkAAny, bkBAny;
  logic [BANK_W-1:0]  bkAMasked, bkBMasked;

  assign bkAMasked = bankAWord & ~MASK_A;
  assign bkBMasked = bankBWord & ~MASK_B;

  irqLsbEncoder #(.W(LOC_N)) locEnc_i (
    .vec(sumWord[LOC_N-1:0]), .idx(locIdx), .any(locAny));
  irqLsbEncoder #(.W(SHA_N)) shAEnc_i (
    .vec(sumWord[SHA_LO +: SHA_N]), .idx(shAIdx), .any(shAAny));
  irqLsbEncoder #(.W(SHB_N)) shBEnc_i (
    .vec(sumWord[SHB_LO +: SHB_N]), .idx(shBIdx), .any(shBAny));
  irqLsbEncoder #(.W(BANK_W)) bkAEnc_i (
    .vec(bkAMasked), .idx(bkAIdx), .any(bkAAny));
  irqLsbEncoder #(.W(BANK_W)) bkBEnc_i (
    .vec(bkBMasked), .idx(bkBIdx), .any(bkBAny));

  always_comb begin
    hits.locHit = locAny;
    hits.shAHit = shAAny;
    hits.shBHit = shBAny;
    hits.bkAHit = sumWord[FLAG_A_POS] & bkAAny;
    hits.bkBHit = sumWord[FLAG_B_POS] & bkBAny;
  end

  logic [NUM_W-1:0] numLoc, numShA, numShB, numBkA, numBkB, nxtNum;
  logic             nxtValid;

  always_comb begin
    numLoc = NUM_W'(locIdx);
    numShA = NUM_W'(BANKA_BASE) + NUM_W'(lineAt(TBL_W'(SHA_LINES), SHA_N, int'(shAIdx)));
    numShB = NUM_W'(BANKB_BASE) + NUM_W'(lineAt(TBL_W'(SHB_LINES), SHB_N, int'(shBIdx)));
    numBkA = NUM_W'(BANKA_BASE) + NUM_W'(bkAIdx);
    numBkB = NUM_W'(BANKB_BASE) + NUM_W'(bkBIdx);
  end

  always_comb begin
    nxtValid = |sel;
    nxtNum   = '0;
    if (sel.selLoc) nxtNum = numLoc;
    if (sel.selShA) nxtNum = numShA;
    if (sel.selShB) nxtNum = numShB;
    if (sel.selBkA) nxtNum = numBkA;
    if (sel.selBkB) nxtNum = numBkB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqNum   <= '0;
    end else begin
      irqValid <= nxtValid;
      irqNum   <= nxtNum;
    end
  end
endmodule

// File: rtl/irqResolver.sv
module irqResolver
  import irqResolver_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SUM_W-1:0]  sumWord,
  input  logic [BANK_W-1:0] bankAWord,
  input  logic [BANK_W-1:0] bankBWord,
  output logic [NUM_W-1:0]  irqNum,
  output logic              irqValid
);
  hitFlags_t hits;
  stageSel_t sel;

  irqResolverCtrl ctrl_i (.hits(hits), .sel(sel));

  irqResolverDp dp_i (
    .clk(clk), .rstN(rstN), .sumWord(sumWord), .bankAWord(bankAWord),
    .bankBWord(bankBWord), .sel(sel), .hits(hits), .irqNum(irqNum),
    .irqValid(irqValid));
endmodule

// File: rtl/irqResolver_chk.sv
module irqResolver_chk
  import irqResolver_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [SUM_W-1:0]  sumWord,
  input logic [BANK_W-1:0] bankAWord,
  input logic [BANK_W-1:0] bankBWord,
  input logic [NUM_W-1:0]  irqNum,
  input logic              irqValid
);
  logic noEarly, noBankHit;
  assign noEarly   = (sumWord[LOC_N-1:0] == '0) && (sumWord[SUM_W-1:SHA_LO] == '0);
  assign noBankHit = !(sumWord[FLAG_A_POS] && |(bankAWord & ~MASK_A)) &&
                     !(sumWord[FLAG_B_POS] && |(bankBWord & ~MASK_B));

  a_r1_zero_summary: assert property (@(posedge clk) disable iff (!rstN)
    sumWord == '0 |=> !irqValid && irqNum == '0);

  a_r2_local_range: assert property (@(posedge clk) disable iff (!rstN)
    |sumWord[LOC_N-1:0] |=> irqValid && irqNum < NUM_W'(LOC_N));

  a_r3_shortcut_a_range: assert property (@(posedge clk) disable iff (!rstN)
    sumWord[LOC_N-1:0] == '0 && |sumWord[SHA_LO +: SHA_N]
    |=> irqValid && irqNum >= NUM_W'(BANKA_BASE) && irqNum < NUM_W'(BANKB_BASE));

  a_r4_shortcut_b_range: assert property (@(posedge clk) disable iff (!rstN)
    sumWord[LOC_N-1:0] == '0 && sumWord[SHA_LO +: SHA_N] == '0 && |sumWord[SHB_LO +: SHB_N]
    |=> irqValid && irqNum >= NUM_W'(BANKB_BASE));

  a_r7_nothing_found: assert property (@(posedge clk) disable iff (!rstN)
    noEarly && noBankHit |=> !irqValid);

  a_r10_idle_number: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> irqNum == '0);
endmodule

bind irqResolver irqResolver_chk chk_i (
  .clk(clk), .rstN(rstN), .sumWord(sumWord), .bankAWord(bankAWord),
  .bankBWord(bankBWord), .irqNum(irqNum), .irqValid(irqValid));

// File: tb/irqResolver_tb_top.sv
`timescale 1ns/1ps
module irqResolver_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] sumWord = '0;
  logic [31:0] bankAWord = '0;
  logic [31:0] bankBWord = '0;
  logic [6:0]  irqNum;
  logic        irqValid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqResolver dut_i (
    .clk(clk), .rstN(rstN), .sumWord(sumWord), .bankAWord(bankAWord),
    .bankBWord(bankBWord), .irqNum(irqNum), .irqValid(irqValid));

  typedef struct packed {
    logic [7:0]  req;
    logic [20:0] s;
    logic [31:0] a;
    logic [31:0] b;
    logic        v;
    logic [6:0]  n;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 21'h000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 7'd0 },  // R1 banks ignored
    '{8'd2, 21'h000084, 32'h0,        32'h0,        1'b1, 7'd2 },  // R2 lowest local
    '{8'd2, 21'h000080, 32'h0,        32'h0,        1'b1, 7'd7 },  // R2
    '{8'd3, 21'h005000, 32'h0,        32'h0,        1'b1, 7'd18},  // R3 line 10 before 19
    '{8'd3, 21'h000C00, 32'h0,        32'h0,        1'b1, 7'd15},  // R3 line 7
    '{8'd4, 21'h110000, 32'h0,        32'h0,        1'b1, 7'd62},  // R4 line 22 before 30
    '{8'd4, 21'h100000, 32'h0,        32'h0,        1'b1, 7'd70},  // R4 line 30
    '{8'd8, 21'h00C000, 32'h0,        32'h0,        1'b1, 7'd27},  // R8 A shortcut beats B
    '{8'd5, 21'h000100, 32'h00001080, 32'h0,        1'b1, 7'd20},  // R5 line 7 masked
    '{8'd7, 21'h000100, 32'h00000680, 32'h0,        1'b0, 7'd0 },  // R7 masked empty
    '{8'd7, 21'h000300, 32'h00000680, 32'h80200000, 1'b1, 7'd71},  // R7 fall through, R6
    '{8'd6, 21'h000200, 32'h0,        32'h00000001, 1'b1, 7'd40},  // R6
    '{8'd8, 21'h000300, 32'h80000000, 32'h00000001, 1'b1, 7'd39},  // R8 bank A beats B
    '{8'd8, 21'h000401, 32'h0,        32'h0,        1'b1, 7'd0 },  // R8 local beats shortcut
    '{8'd7, 21'h000200, 32'hFFFFFFFF, 32'h00000020, 1'b1, 7'd45},  // R7 unflagged A ignored
    '{8'd5, 21'h000100, 32'h80000000, 32'h0,        1'b1, 7'd39}   // R5 top line
  };

  task automatic check(input string req, input logic expV, input logic [6:0] expN);
    checks++;
    if (irqValid !== expV || irqNum !== expN) begin
      errors++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               req, irqValid, irqNum, expV, expN);
    end
  endtask

  task automatic apply(input logic [20:0] s, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    sumWord = s; bankAWord = a; bankBWord = b;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9 reset state, with inputs that would otherwise give a result
    sumWord = 21'h000001;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 7'd0);
    rstN = 1'b1;
    apply(21'h0, 32'h0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].s, VECS[i].a, VECS[i].b);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].v, VECS[i].n);
    end

    // R9 latency: new inputs must not show before the next rising edge
    apply(21'h000008, 32'h0, 32'h0);
    @(negedge clk);
    check("R9 settle", 1'b1, 7'd3);
    apply(21'h100000, 32'h0, 32'h0);
    #1;
    check("R9 held before edge", 1'b1, 7'd3);
    @(negedge clk);
    check("R9 after edge", 1'b1, 7'd70);

    // R9 asynchronous reset mid-run, R10 number zero while invalid
    #0.5 rstN = 1'b0;
    #0.5;
    check("R9 async reset", 1'b0, 7'd0);
    @(negedge clk);
    rstN = 1'b1;
    check("R10 held in reset", 1'b0, 7'd0);
    @(negedge clk);
    check("R9 recover", 1'b1, 7'd70);

    // R10 drop to no result after a valid number
    apply(21'h000100, 32'h000C0680, 32'h0);
    @(negedge clk);
    check("R10 invalid after valid", 1'b0, 7'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule